// File: doc/BRIEF.md
# Conditional Trap Compare Unit

This block decides whether a conditional trap instruction fires. It takes two operands, a five-bit condition mask, a width select and a valid strobe. Each condition bit enables one relation between the operands (signed less-than, signed greater-than, equality, unsigned less-than, unsigned greater-than). The trap fires when at least one enabled relation holds.

The width select chooses between a doubleword compare over all 64 bits and a word compare over only the low 32 bits. In the word compare, bit 31 acts as the sign bit. The result is registered: one cycle after the strobe, the block presents a result-valid pulse, a trap flag and a cause code. Operand decode upstream and exception entry downstream belong to other blocks.

Top module: `trap_compare_unit`

## Requirements
- R1: Condition bit 4 (mask value 0x10) makes the trap fire when operand A is less than operand B as two's-complement numbers.
- R2: Condition bit 3 (mask value 0x08) makes the trap fire when A is greater than B as two's-complement numbers.
- R3: Condition bit 2 (mask value 0x04) makes the trap fire when A equals B.
- R4: Condition bit 1 (mask value 0x02) makes the trap fire on unsigned A less than B. Condition bit 0 (mask value 0x01) makes it fire on unsigned A greater than B.
- R5: The trap fires exactly when at least one enabled relation holds.
- R6: With `wide` low (word form), only bits 31:0 of each operand are compared and bit 31 is the sign bit. Bits 63:32 have no effect on the result.
- R7: With `wide` high (doubleword form), all 64 bits are compared and bit 63 is the sign bit.
- R8: A condition mask of 0x00 never traps, and a mask of 0x1F always traps.
- R9: `res_valid` is high in the cycle after a cycle with `in_valid` high, and low otherwise. `trap_req` is only high while `res_valid` is high.
- R10: `trap_cause` is 0x24 (program class 2, trap sub-cause 4) while `trap_req` is high, and 0x00 otherwise.
- R11: After a synchronous reset, `res_valid` and `trap_req` are 0 and `trap_cause` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands and mask are valid this cycle |
| opa | input | 64 | Operand A |
| opb | input | 64 | Operand B |
| cond | input | 5 | Condition mask: bit 4 slt, 3 sgt, 2 eq, 1 ult, 0 ugt |
| wide | input | 1 | 1 = doubleword compare, 0 = word compare |
| res_valid | output | 1 | Result valid, one cycle after in_valid |
| trap_req | output | 1 | Trap fires |
| trap_cause | output | 8 | Cause code: 0x24 on trap, 0x00 otherwise |

## Verification
Every defect in this block shows at the ports one cycle after the strobe, because there is a single register stage. Suppose the relation flags are wrong, one mask bit is mapped to the wrong flag, or the width mux leaks upper bits. Then `trap_req` differs from the arithmetic expectation for some operand pair chosen at the sign and carry boundaries. The sweep crosses every mask value and both widths with operands that differ only above bit 31 or only in bit 31 or 63, so such a fault shows up on the very next result. A register stage that holds stale values shows up as `res_valid` or `trap_cause` staying high in a cycle with no strobe.

// File: rtl/trap_cmp_pkg.sv
package trap_cmp_pkg;

    parameter int unsigned XLEN    = 64;
    parameter int unsigned HALF    = 32;
    parameter int unsigned COND_W  = 5;
    parameter int unsigned CAUSE_W = 8;

    // Field order matches the condition mask, bit 4 down to bit 0.
    typedef struct packed {
        logic s_lt;
        logic s_gt;
        logic eq;
        logic u_lt;
        logic u_gt;
    } rel_t;

    typedef enum logic [CAUSE_W-1:0] {
        CAUSE_NONE      = 8'h00,
        CAUSE_PROG_TRAP = 8'h24
    } cause_e;

    function automatic logic any_enabled(input rel_t r, input logic [COND_W-1:0] c);
        logic [COND_W-1:0] rv;
        rv = r;
        return |(rv & c);
    endfunction

endpackage

// File: rtl/trap_rel_core.sv
module trap_rel_core
    import trap_cmp_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output rel_t         rel
);
    always_comb begin
        rel.s_lt = $signed(a) <  $signed(b);
        rel.s_gt = $signed(a) >  $signed(b);
        rel.eq   = (a == b);
        rel.u_lt = a < b;
        rel.u_gt = a > b;
    end
endmodule

// File: rtl/trap_width_sel.sv
module trap_width_sel
    import trap_cmp_pkg::*;
#(
    parameter int unsigned DATA_W = XLEN,
    parameter int unsigned WORD_W = HALF
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              wide,
    output rel_t              rel
);
    rel_t rel_word;

    trap_rel_core #(.W(WORD_W)) u_word (
        .a   (a[WORD_W-1:0]),
        .b   (b[WORD_W-1:0]),
        .rel (rel_word)
    );

    generate
        if (DATA_W > WORD_W) begin : g_dual
            rel_t rel_full;
            trap_rel_core #(.W(DATA_W)) u_full (
                .a   (a),
                .b   (b),
                .rel (rel_full)
            );
            assign rel = wide ? rel_full : rel_word;
        end else begin : g_single
            logic unused_wide;
            assign unused_wide = wide;
            assign rel = rel_word;
        end
    endgenerate
endmodule

// File: rtl/trap_cond_eval.sv
module trap_cond_eval
    import trap_cmp_pkg::*;
(
    input  rel_t              rel,
    input  logic [COND_W-1:0] cond,
    output logic              hit
);
    assign hit = any_enabled(rel, cond);
endmodule

// File: rtl/trap_compare_unit.sv
module trap_compare_unit
    import trap_cmp_pkg::*;
#(
    parameter int unsigned DATA_W = XLEN,
    parameter int unsigned WORD_W = HALF
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [DATA_W-1:0]    opa,
    input  logic [DATA_W-1:0]    opb,
    input  logic [COND_W-1:0]    cond,
    input  logic                 wide,
    output logic                 res_valid,
    output logic                 trap_req,
    output logic [CAUSE_W-1:0]   trap_cause
);
    rel_t   rel;
    logic   hit;
    logic   vld_q;
    logic   trap_q;
    cause_e cause_q;

    trap_width_sel #(.DATA_W(DATA_W), .WORD_W(WORD_W)) u_width (
        .a    (opa),
        .b    (opb),
        .wide (wide),
        .rel  (rel)
    );

    trap_cond_eval u_eval (
        .rel  (rel),
        .cond (cond),
        .hit  (hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q   <= 1'b0;
            trap_q  <= 1'b0;
            cause_q <= CAUSE_NONE;
        end else begin
            vld_q   <= in_valid;
            trap_q  <= in_valid && hit;
            cause_q <= (in_valid && hit) ? CAUSE_PROG_TRAP : CAUSE_NONE;
        end
    end

    assign res_valid  = vld_q;
    assign trap_req   = trap_q;
    assign trap_cause = cause_q;
endmodule

// File: rtl/trap_compare_checker.sv
module trap_compare_checker
    import trap_cmp_pkg::*;
#(
    parameter int unsigned DATA_W = XLEN
) (
    input logic               clk,
    input logic               rst,
    input logic               in_valid,
    input logic [DATA_W-1:0]  opa,
    input logic [DATA_W-1:0]  opb,
    input logic [COND_W-1:0]  cond,
    input logic               wide,
    input logic               res_valid,
    input logic               trap_req,
    input logic [CAUSE_W-1:0] trap_cause
);
    assert_valid_follows_R9: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> res_valid);
    assert_valid_idle_R9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !res_valid);
    assert_trap_qualified_R9: assert property (@(posedge clk) disable iff (rst)
        trap_req |-> res_valid);
    assert_cause_trap_R10: assert property (@(posedge clk) disable iff (rst)
        trap_req |-> trap_cause == 8'h24);
    assert_cause_idle_R10: assert property (@(posedge clk) disable iff (rst)
        !trap_req |-> trap_cause == 8'h00);
    assert_mask_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && cond == '0) |=> !trap_req);
    assert_mask_full_R8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && cond == 5'h1F) |=> trap_req);
    assert_word_equal_R6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !wide && cond[2] && opa[31:0] == opb[31:0]) |=> trap_req);
    assert_full_equal_R3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && wide && cond[2] && opa == opb) |=> trap_req);
endmodule

bind trap_compare_unit trap_compare_checker #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/test_trap_compare_unit.sv
module test_trap_compare_unit;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;
    localparam int NVAL       = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [63:0] opa, opb;
    logic [4:0]  cond;
    logic        wide;
    logic        res_valid, trap_req;
    logic [7:0]  trap_cause;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    trap_compare_unit i_trap_compare_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .opa(opa), .opb(opb),
        .cond(cond), .wide(wide), .res_valid(res_valid), .trap_req(trap_req),
        .trap_cause(trap_cause)
    );

    function automatic logic [63:0] pick(input int i);
        case (i)
            0: return 64'h0;
            1: return 64'h1;
            2: return 64'h0000_0000_7FFF_FFFF;
            3: return 64'h0000_0000_8000_0000;
            4: return 64'h0000_0000_FFFF_FFFF;
            5: return 64'h8000_0000_0000_0000;
            6: return 64'h7FFF_FFFF_FFFF_FFFF;
            7: return 64'hFFFF_FFFF_FFFF_FFFF;
            8: return 64'h0000_0001_0000_0000;
            default: return 64'hABCD_0000_0000_0005;
        endcase
    endfunction

    function automatic bit model(input logic [63:0] a, input logic [63:0] b,
                                 input logic [4:0] c, input bit w);
        longint sa, sb;
        longint unsigned ua, ub;
        if (w) begin
            sa = longint'(a); sb = longint'(b); ua = a; ub = b;
        end else begin
            sa = longint'($signed(a[31:0])); sb = longint'($signed(b[31:0]));
            ua = {32'h0, a[31:0]}; ub = {32'h0, b[31:0]};
        end
        return (c[4] && sa < sb) || (c[3] && sa > sb) || (c[2] && ua == ub) ||
               (c[1] && ua < ub) || (c[0] && ua > ub);
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Drive one operation; on return the registered result is on the outputs.
    task automatic apply(input logic [63:0] a, input logic [63:0] b,
                         input logic [4:0] c, input bit w);
        @(negedge clk);
        opa = a; opb = b; cond = c; wide = w; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic run_one(input string tag, input logic [63:0] a, input logic [63:0] b,
                           input logic [4:0] c, input bit w);
        bit e;
        e = model(a, b, c, w);
        apply(a, b, c, w);
        check({tag, " trap"}, {63'h0, trap_req}, {63'h0, e});
        check("R10 cause", {56'h0, trap_cause}, e ? 64'h24 : 64'h0);
        check("R9 valid", {63'h0, res_valid}, 64'h1);
    endtask

    initial begin
        rst = 1'b1; in_valid = 1'b0; opa = '0; opb = '0; cond = '0; wide = 1'b0;
        repeat (3) @(negedge clk);
        check("R11 reset valid", {63'h0, res_valid}, 64'h0);
        check("R11 reset trap", {63'h0, trap_req}, 64'h0);
        check("R11 reset cause", {56'h0, trap_cause}, 64'h0);
        rst = 1'b0;

        // Directed cases
        run_one("R1 slt",  64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 5'h10, 1'b1);
        run_one("R1 slt no", 64'h1, 64'hFFFF_FFFF_FFFF_FFFF, 5'h10, 1'b1);
        run_one("R2 sgt",  64'h5, 64'h8000_0000_0000_0000, 5'h08, 1'b1);
        run_one("R3 eq",   64'h1234, 64'h1234, 5'h04, 1'b1);
        run_one("R4 ult",  64'h1, 64'hFFFF_FFFF_FFFF_FFFF, 5'h02, 1'b1);
        run_one("R4 ugt",  64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 5'h01, 1'b1);
        run_one("R6 word sign", 64'h0000_0000_8000_0000, 64'h0, 5'h10, 1'b0);
        run_one("R6 upper ignored", 64'hFFFF_0000_0000_0007, 64'h0000_FFFF_0000_0007, 5'h04, 1'b0);
        run_one("R7 upper used", 64'hFFFF_0000_0000_0007, 64'h0000_FFFF_0000_0007, 5'h04, 1'b1);
        run_one("R8 zero mask", 64'h3, 64'h9, 5'h00, 1'b1);
        run_one("R8 full mask", 64'h3, 64'h3, 5'h1F, 1'b0);

        // R9: no strobe, outputs fall back
        @(negedge clk);
        check("R9 idle valid", {63'h0, res_valid}, 64'h0);
        check("R9 idle trap", {63'h0, trap_req}, 64'h0);
        check("R10 idle cause", {56'h0, trap_cause}, 64'h0);

        // Sweep: R5 over all masks, both widths, boundary operand pairs
        for (int w = 0; w < 2; w++)
            for (int c = 0; c < 32; c++)
                for (int i = 0; i < NVAL; i++)
                    for (int j = 0; j < NVAL; j++)
                        run_one(w != 0 ? "R5 R7 sweep" : "R5 R6 sweep",
                                pick(i), pick(j), 5'(c), w != 0);

        // R11: reset in the middle of a result
        @(negedge clk);
        opa = 64'h0; opb = 64'h0; cond = 5'h1F; in_valid = 1'b1; rst = 1'b1;
        @(negedge clk);
        in_valid = 1'b0; rst = 1'b0;
        check("R11 reset overrides", {63'h0, trap_req}, 64'h0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int k = 0; k < WATCHDOG; k++) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule